// File: doc/BRIEF.md
# Shadow-Latched Multi-Channel PWM Timer

This block drives several single-edge PWM outputs from one shared up-counter. A programmable prescaler divides the input clock and produces a count tick. The counter runs from zero up to a period limit and then restarts at zero. Each output goes high when a period starts and goes low once the counter reaches that output's own threshold.

Software programs the block over a small synchronous register bus. Every written period or threshold value first lands in a shadow register. A value reaches its active register only at a period boundary, and only if software has armed that register's latch bit. Each latch bit clears itself once its transfer has happened. A control register can hold the timer in a quiet reset, enable counting, and enable output drive. When the hold is released, all shadow values take effect together and the count starts from zero.

The default build has six outputs, a 16-bit counter and an 8-bit prescaler.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After `rst_n` is released, every register reads 0 and all outputs are low.
- R2: The register map is as follows. Addresses 0..6 hold the shadow values of the period limit (address 0) and of thresholds 1..6. Address 7 holds the latch bits, where bit k arms the register at address k. Address 8 holds the prescale value in bits 7:0. Address 9 holds the control register. Reads are combinational and return the stored value, zero-extended. Control bit 2 always reads 0. Addresses 10..15 read 0, and writes to them change nothing.
- R3: Control bit 1 (hold) forces the counter and the prescaler to zero and drives all outputs low. When control bit 3 (drive) is clear, all outputs are low.
- R4: With control bit 0 set and hold clear, the counter advances once every P+1 clocks, where P is the prescale value. The prescaler restarts when its own count is at or above P.
- R5: The counter takes the values 0..M0 and then returns to 0, where M0 is the active period limit. One period therefore lasts (M0+1)(P+1) clocks.
- R6: Output n is high while the count is below its active threshold Mn and low otherwise. With M0=18, M6=9 and P=0, output 6 is high for 9 of every 19 clocks.
- R7: An active threshold of 0 keeps its output low for the whole period. A threshold above M0 keeps its output high for the whole period.
- R8: A write to a shadow register leaves its active register unchanged. The value is transferred only at the tick that returns the counter to 0, and only if the register's latch bit is set.
- R9: At that tick, all latch bits clear. A latch write made in the same cycle takes precedence over the clear.
- R10: While hold is set, every active register follows its shadow register. After hold is released, counting starts at 0 with all shadow values in effect.
- R11: With control bit 0 clear, the counter and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pwm_out | output | 6 | PWM outputs; bit 0 is output 1 |

## Verification
On every cycle, the assertions check these properties:
- The counter never exceeds the active period limit.
- A tick moves the counter by exactly one, and the counter freezes when counting is disabled.
- Hold zeroes both counters.
- The active registers change only at a boundary or under hold.
- The latch bits are empty after a boundary.
- The outputs stay low when drive is off.

Some behaviour only the bench's scenarios can show, because it needs a full period or a chosen value to be observed:
- The exact duty and period counts in clocks.
- The deferred effect of an unlatched write.
- The saturation cases for thresholds of zero and above the period.
- The read-back map.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CTL_W    = 4;
  localparam int CTL_RUN  = 0;
  localparam int CTL_HOLD = 1;
  localparam int CTL_PWM  = 3;
  localparam logic [CTL_W-1:0] CTL_MASK = 4'b1011;

  function automatic int addr_latch(input int nch);
    return nch + 1;
  endfunction

  function automatic int addr_pre(input int nch);
    return nch + 2;
  endfunction

  function automatic int addr_ctl(input int nch);
    return nch + 3;
  endfunction
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             tick,
  output logic [PRE_W-1:0] pre_cnt
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick = run && (cnt_q >= limit);

  always_comb begin
    cnt_en = hold || run;
    cnt_d  = cnt_q;
    if (hold)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pre_cnt = cnt_q;
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign wrap = tick && (cnt_q == period);

  always_comb begin
    cnt_en = hold || tick;
    cnt_d  = cnt_q;
    if (hold || wrap) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int NMR   = 7,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hold,
  input  logic                      wrap,
  input  logic [NMR-1:0]            sh_we,
  input  logic [CNT_W-1:0]          wdata,
  input  logic                      le_wr,
  input  logic [NMR-1:0]            le_wdata,
  output logic [NMR-1:0][CNT_W-1:0] shadow,
  output logic [NMR-1:0][CNT_W-1:0] active,
  output logic [NMR-1:0]            le
);
  logic [NMR-1:0] le_q, le_d;

  for (genvar i = 0; i < NMR; i++) begin : g_mr
    logic [CNT_W-1:0] sh_q, sh_d, act_q, act_d;
    logic             act_en;

    always_comb begin
      sh_d   = sh_we[i] ? wdata : sh_q;
      act_en = hold || (wrap && le_q[i]);
      act_d  = act_en ? sh_q : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (sh_we[i]) sh_q  <= sh_d;
        if (act_en)   act_q <= act_d;
      end
    end

    assign shadow[i] = sh_q;
    assign active[i] = act_q;
  end

  always_comb begin
    le_d = le_q;
    if (le_wr)     le_d = le_wdata;
    else if (wrap) le_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) le_q <= '0;
    else        le_q <= le_d;
  end

  assign le = le_q;
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int NCH   = 6,
  parameter int CNT_W = 16
) (
  input  logic                      drive,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [NCH:0][CNT_W-1:0]   active,
  output logic [NCH-1:0]            pwm_out
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign pwm_out[ch] = drive && (cnt < active[ch+1]);
  end
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
  import pwm_pkg::*;
#(
  parameter  int NCH   = 6,
  parameter  int CNT_W = 16,
  parameter  int PRE_W = 8,
  localparam int NMR   = NCH + 1,
  localparam int AW    = $clog2(NCH + 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic [NCH-1:0]   pwm_out
);
  localparam int A_LE  = addr_latch(NCH);
  localparam int A_PRE = addr_pre(NCH);
  localparam int A_CTL = addr_ctl(NCH);

  logic                      srst_n;
  logic [CTL_W-1:0]          ctl_q, ctl_d;
  logic [PRE_W-1:0]          pr_q, pr_d;
  logic                      ctl_wr, pr_wr, le_wr;
  logic [NMR-1:0]            sh_we;
  logic                      hold, run, pwm_mode, tick, wrap;
  logic [PRE_W-1:0]          pre_cnt;
  logic [CNT_W-1:0]          cnt;
  logic [NMR-1:0][CNT_W-1:0] shadow, active;
  logic [NMR-1:0]            le_q;

  pwm_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  always_comb begin
    ctl_wr = bus_we && (bus_addr == AW'(A_CTL));
    pr_wr  = bus_we && (bus_addr == AW'(A_PRE));
    le_wr  = bus_we && (bus_addr == AW'(A_LE));
    for (int i = 0; i < NMR; i++) sh_we[i] = bus_we && (bus_addr == AW'(i));
    ctl_d  = bus_wdata[CTL_W-1:0] & CTL_MASK;
    pr_d   = bus_wdata[PRE_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= '0;
      pr_q  <= '0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_d;
      if (pr_wr)  pr_q  <= pr_d;
    end
  end

  assign hold     = ctl_q[CTL_HOLD];
  assign run      = ctl_q[CTL_RUN] && !hold;
  assign pwm_mode = ctl_q[CTL_PWM];

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(srst_n), .hold(hold), .run(run),
    .limit(pr_q), .tick(tick), .pre_cnt(pre_cnt)
  );

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .hold(hold), .tick(tick),
    .period(active[0]), .cnt(cnt), .wrap(wrap)
  );

  pwm_match_bank #(.NMR(NMR), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(srst_n), .hold(hold), .wrap(wrap),
    .sh_we(sh_we), .wdata(bus_wdata), .le_wr(le_wr),
    .le_wdata(bus_wdata[NMR-1:0]), .shadow(shadow),
    .active(active), .le(le_q)
  );

  pwm_out_stage #(.NCH(NCH), .CNT_W(CNT_W)) u_out (
    .drive(pwm_mode && !hold), .cnt(cnt), .active(active),
    .pwm_out(pwm_out)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NMR; i++)
      if (bus_addr == AW'(i)) bus_rdata = shadow[i];
    if (bus_addr == AW'(A_LE))  bus_rdata[NMR-1:0]   = le_q;
    if (bus_addr == AW'(A_PRE)) bus_rdata[PRE_W-1:0] = pr_q;
    if (bus_addr == AW'(A_CTL)) bus_rdata[CTL_W-1:0] = ctl_q;
  end
endmodule

// File: rtl/pwm_shadow_timer_chk.sv
module pwm_shadow_timer_chk #(
  parameter int NCH   = 6,
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input logic                        clk,
  input logic                        srst_n,
  input logic                        hold,
  input logic                        run,
  input logic                        pwm_mode,
  input logic                        tick,
  input logic                        wrap,
  input logic                        le_wr,
  input logic [PRE_W-1:0]            pre_cnt,
  input logic [CNT_W-1:0]            cnt,
  input logic [NCH:0][CNT_W-1:0]     active,
  input logic [NCH:0]                le_q,
  input logic [NCH-1:0]              pwm_out
);
  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    hold |=> (cnt == '0 && pre_cnt == '0));

  // R3
  quiet_out_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!pwm_mode || hold) |-> (pwm_out == '0));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cnt <= active[0]);

  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  // R11
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!run && !hold) |=> $stable(cnt));

  // R8
  act_stable_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(wrap || hold) |=> $stable(active));

  // R9
  latch_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wrap && !le_wr) |=> (le_q == '0));
endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .srst_n(srst_n), .hold(hold), .run(run),
  .pwm_mode(pwm_mode), .tick(tick), .wrap(wrap), .le_wr(le_wr),
  .pre_cnt(pre_cnt), .cnt(cnt), .active(active), .le_q(le_q),
  .pwm_out(pwm_out)
);

// File: tb/tb_pwm_shadow_timer.sv
module tb_pwm_shadow_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [5:0]  pwm_out;

  always #4 clk = ~clk;

  pwm_shadow_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int unsigned vecs = 0;
  int unsigned miss = 0;
  bit          done = 0;
  string       cur_tag = "R1";
  logic [5:0]  seen_out;

  // reference state
  logic [15:0] m_sh [7];
  logic [15:0] m_act[7];
  logic [6:0]  m_le;
  logic [7:0]  m_pr, m_pc;
  logic [3:0]  m_ctl;
  logic [15:0] m_tc;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_read(input logic [3:0] a);
    if (a <= 4'd6)  return m_sh[a];
    if (a == 4'd7)  return {9'd0, m_le};
    if (a == 4'd8)  return {8'd0, m_pr};
    if (a == 4'd9)  return {12'd0, m_ctl};
    return 16'd0;
  endfunction

  function automatic logic [5:0] ref_out();
    logic [5:0] o;
    for (int n = 0; n < 6; n++)
      o[n] = m_ctl[3] && !m_ctl[1] && (m_tc < m_act[n+1]);
    return o;
  endfunction

  task automatic cyc(input logic we, input logic [3:0] a, input logic [15:0] d);
    logic        hold, run, tick, wrap;
    logic [15:0] n_sh[7];
    logic [15:0] n_act[7];
    logic [6:0]  n_le;
    logic [7:0]  n_pr, n_pc;
    logic [3:0]  n_ctl;
    logic [15:0] n_tc;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    seen_out = pwm_out;
    check(cur_tag, {10'd0, pwm_out}, {10'd0, ref_out()});
    check(cur_tag, bus_rdata, ref_read(a));
    hold = m_ctl[1];
    run  = m_ctl[0] && !hold;
    tick = run && (m_pc >= m_pr);
    wrap = tick && (m_tc == m_act[0]);
    n_pc = hold ? 8'd0 : tick ? 8'd0 : run ? m_pc + 8'd1 : m_pc;
    n_tc = hold ? 16'd0 : wrap ? 16'd0 : tick ? m_tc + 16'd1 : m_tc;
    for (int i = 0; i < 7; i++) begin
      n_act[i] = (hold || (wrap && m_le[i])) ? m_sh[i] : m_act[i];
      n_sh[i]  = (we && a == 4'(i)) ? d : m_sh[i];
    end
    n_le  = (we && a == 4'd7) ? d[6:0] : wrap ? 7'd0 : m_le;
    n_pr  = (we && a == 4'd8) ? d[7:0] : m_pr;
    n_ctl = (we && a == 4'd9) ? (d[3:0] & 4'b1011) : m_ctl;
    @(posedge clk);
    m_sh = n_sh; m_act = n_act; m_le = n_le; m_pr = n_pr;
    m_pc = n_pc; m_tc = n_tc; m_ctl = n_ctl;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 4'(k % 10), 16'd0);
  endtask

  // clocks high on output ch over a window of n clocks
  task automatic high_count(input int ch, input int n, output int hc);
    hc = 0;
    for (int k = 0; k < n; k++) begin
      cyc(1'b0, 4'd0, 16'd0);
      if (seen_out[ch]) hc++;
    end
  endtask

  initial begin
    int hc, r1, r2, cnt_c;
    logic prev;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 7; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    m_le = '0; m_pr = '0; m_pc = '0; m_ctl = '0; m_tc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: all addresses read zero, outputs low
    cur_tag = "R1";
    for (int a = 0; a < 16; a++) cyc(1'b0, 4'(a), 16'd0);

    // R2: program shadows, prescale, latch; unmapped writes ignored
    cur_tag = "R2";
    cyc(1'b1, 4'd0, 16'd18); cyc(1'b1, 4'd1, 16'd0);  cyc(1'b1, 4'd2, 16'd40);
    cyc(1'b1, 4'd3, 16'd1);  cyc(1'b1, 4'd4, 16'd18); cyc(1'b1, 4'd5, 16'd10);
    cyc(1'b1, 4'd6, 16'd9);  cyc(1'b1, 4'd8, 16'h0000);
    cyc(1'b1, 4'd12, 16'hFFFF); cyc(1'b1, 4'd7, 16'h0055);
    cyc(1'b1, 4'd9, 16'h000F);
    for (int a = 0; a < 16; a++) cyc(1'b0, 4'(a), 16'd0);
    check("R2", bus_rdata, 16'd0);

    // R10: hold then release with drive on
    cur_tag = "R10";
    idle(5);
    cyc(1'b1, 4'd9, 16'h0009);
    idle(25);

    // R6: 19-clock period, output 6 high 9 clocks
    cur_tag = "R6";
    high_count(5, 19, hc);
    check("R6", 16'(hc), 16'd9);

    // R7: threshold 0 stays low, threshold above period stays high
    cur_tag = "R7";
    for (int k = 0; k < 20; k++) begin
      cyc(1'b0, 4'd0, 16'd0);
      check("R7", {15'd0, seen_out[0]}, 16'd0);
      check("R7", {15'd0, seen_out[1]}, 16'd1);
    end

    // R4/R5: prescale 2, period limit 5 -> 18 clocks per period
    cur_tag = "R4";
    cyc(1'b1, 4'd8, 16'd2); cyc(1'b1, 4'd0, 16'd5); cyc(1'b1, 4'd7, 16'h0001);
    idle(60);
    cur_tag = "R5";
    r1 = -1; r2 = -1; cnt_c = 0; prev = 1'b1;
    for (int k = 0; k < 80 && r2 < 0; k++) begin
      cyc(1'b0, 4'd0, 16'd0);
      if (seen_out[2] && !prev) begin
        if (r1 < 0) r1 = k; else r2 = k;
      end
      prev = seen_out[2];
    end
    check("R5", 16'(r2 - r1), 16'd18);

    // R8: shadow write without latch bit leaves threshold 3 at 1
    cur_tag = "R8";
    cyc(1'b1, 4'd3, 16'd4);
    idle(40);
    high_count(2, 18, hc);
    check("R8", 16'(hc), 16'd3);

    // R9: arm latch, transfer at boundary, bit self-clears
    cur_tag = "R9";
    cyc(1'b1, 4'd7, 16'h0008);
    idle(40);
    cyc(1'b0, 4'd7, 16'd0);
    check("R9", bus_rdata, 16'd0);
    high_count(2, 18, hc);
    check("R9", 16'(hc), 16'd12);

    // R3: drive off, then hold
    cur_tag = "R3";
    cyc(1'b1, 4'd9, 16'h0001); idle(10);
    cyc(1'b1, 4'd9, 16'h000B); idle(10);

    // R11: counting disabled keeps state
    cur_tag = "R11";
    cyc(1'b1, 4'd9, 16'h0009); idle(20);
    cyc(1'b1, 4'd9, 16'h0008); idle(20);

    // random traffic
    cur_tag = "R8";
    for (int k = 0; k < 3000; k++) begin
      logic [3:0]  a;
      logic [15:0] d;
      logic        w;
      a = 4'($urandom_range(0, 15));
      w = ($urandom_range(0, 9) < 3);
      if (a <= 4'd6)      d = 16'($urandom_range(0, 24));
      else if (a == 4'd7) d = 16'($urandom_range(0, 127));
      else if (a == 4'd8) d = 16'($urandom_range(0, 3));
      else if (a == 4'd9) begin
        case ($urandom_range(0, 9))
          0:       d = 16'h0002;
          1:       d = 16'h0008;
          2:       d = 16'($urandom_range(0, 15));
          default: d = 16'h0009;
        endcase
      end else d = 16'($urandom);
      cyc(w, a, d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecs++; miss++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule